// File: doc/BRIEF.md
# Protected Control Register Write Logic

This block guards an 8-bit configuration register that sits behind a two-wire serial slave. A byte engine in front of it does the bit shifting and hands over single-cycle events: a START, a received byte, a STOP and a request for a byte to transmit. The block decides whether each received byte is acknowledged. It only lets the register change after a two-step unlock of write-enable latches. It keeps exactly one data byte per write, and it applies that byte when the STOP arrives. It drives the watchdog period select, the power-up delay select and the protect field to the rest of the chip. A field update is modelled as a register load followed by a fixed busy window, which stands in for the nonvolatile store.

Bus sequencing is a single state machine. After reset it is in `ST_IDLE`. START moves it from any state to `ST_SLAVE`, and STOP moves it from any state to `ST_IDLE`. In `ST_SLAVE`, a matching slave byte moves it to `ST_ADDR` (write) or `ST_READ` (read), and any other slave byte moves it to `ST_SKIP`. In `ST_ADDR`, a matching address moves it to `ST_DATA`, and any other address moves it to `ST_SKIP`. In `ST_DATA`, the data byte is kept and the machine moves to `ST_HOLD`, where further bytes are refused. A STOP seen in `ST_HOLD` is the commit. In `ST_READ`, a transmit request returns the register and moves the machine to `ST_IDLE`, while a byte moves it to `ST_SKIP`. `ST_SKIP` ignores bytes until the next START or STOP.

If several events arrive in one cycle, START wins over STOP, STOP over a byte, and a byte over a transmit request.

Top module: `prot_ctlreg`

## Requirements
- R1: After reset, ack_vld, ack_ok, tx_vld and busy_o are 0. The register is RST_CFG with bits 2 and 1 forced to 0, so with defaults every field output is 0.
- R2: ack_vld is high in the cycle after every received byte, and ack_ok carries the decision. A slave byte is acknowledged only when bits 7:4 are 1011 and bits 3:2 equal DEV_SEL. Bit 0 selects read (1) or write (0). Any other slave byte is refused, and the bytes that follow it are refused until the next START.
- R3: On a write, bit 1 of the slave byte is address bit 8 and the next byte is address bits 7:0. The address is acknowledged only if it equals REG_ADDR (1FFh). Otherwise it and the later bytes are refused and the register does not change.
- R4: Only the first byte after the address is acknowledged and kept as data. Later bytes before the STOP are refused and have no effect.
- R5: The register layout is: bit 7 power-up select high, bit 6 watchdog select high, bit 5 watchdog select low, bit 4 protect high, bit 3 protect low, bit 2 second-stage enable latch, bit 1 first-stage enable latch, bit 0 power-up select low. A committed data byte of 02h sets bit 1 and clears bit 2.
- R6: A committed 06h sets bit 2 only if bit 1 is already set. Otherwise it leaves the register unchanged.
- R7: With both latches set, a committed data byte that has bit 2 set loads bits 7:3 and bit 0 from the data and clears both latches. busy_o then goes high in the cycle after the STOP and stays high for exactly BUSY_CYC cycles.
- R8: A committed 00h clears both latches. In every other case, and whenever both latches are not set or data bit 2 is 0, bits 7:3 and bit 0 stay unchanged and busy_o stays low.
- R9: Nothing changes if a STOP arrives before the data byte, or if a START arrives between the data byte and the STOP.
- R10: After an acknowledged read slave byte, the first transmit request gives tx_vld one cycle later, with tx_byte equal to the whole register. A second request in the same operation gives no tx_vld. No STOP is needed before the next START.
- R11: Every received byte is refused in any cycle where busy_o is high, including the last busy cycle. A slave byte that arrives in the first cycle after busy_o falls is acknowledged normally.
- R12: wd_sel = {bit 6, bit 5}, pup_sel = {bit 7, bit 0} and bp_sel = {bit 4, bit 3} of the register at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START or repeated START seen on the bus |
| ev_stop | input | 1 | STOP seen on the bus |
| ev_byte_vld | input | 1 | A byte from the master is present on ev_byte |
| ev_byte | input | 8 | Received byte |
| ev_rd_req | input | 1 | The engine needs a byte to transmit |
| ack_vld | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_vld | output | 1 | tx_byte is valid |
| tx_byte | output | 8 | Register contents for a read |
| wd_sel | output | 2 | Watchdog period select |
| pup_sel | output | 2 | Power-up delay select |
| bp_sel | output | 2 | Protect field |
| busy_o | output | 1 | Store window after a field update |

## Verification
The commit of a field update and the acknowledge decision for a new slave byte can meet at the edge where the busy window ends. The bench commits a byte and then places a START and a slave byte so that the byte lands exactly on the last busy cycle, which must be refused. It then repeats the commit and moves the byte one cycle later, which must be acknowledged. Cycle positions are counted from the STOP edge with BUSY_CYC, so an off-by-one in the window or in the refusal shows up as a wrong ack_ok.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int DATA_W = 8;

    // register bit positions
    localparam int B_PUP0 = 0;
    localparam int B_WEL  = 1;
    localparam int B_RWEL = 2;
    localparam int B_BP0  = 3;
    localparam int B_BP1  = 4;
    localparam int B_WD0  = 5;
    localparam int B_WD1  = 6;
    localparam int B_PUP1 = 7;

    localparam logic [3:0]        PREAMBLE     = 4'b1011;
    localparam logic [DATA_W-1:0] CMD_SET_WEL  = 8'h02;
    localparam logic [DATA_W-1:0] CMD_SET_RWEL = 8'h06;
    localparam logic [DATA_W-1:0] CMD_DISABLE  = 8'h00;
    localparam logic [DATA_W-1:0] FIELD_MASK   = 8'hF9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLAVE,
        ST_ADDR,
        ST_DATA,
        ST_HOLD,
        ST_READ,
        ST_SKIP
    } bus_st_e;

endpackage

// File: rtl/prot_ctlreg_seq.sv
module prot_ctlreg_seq
    import ctlreg_pkg::*;
#(
    parameter logic [1:0] DEV_SEL  = 2'b00,
    parameter logic [8:0] REG_ADDR = 9'h1FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte_vld,
    input  logic [DATA_W-1:0] ev_byte,
    input  logic              ev_rd_req,
    input  logic              busy,
    input  logic [DATA_W-1:0] cfg,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              tx_vld,
    output logic [DATA_W-1:0] tx_byte,
    output logic              wr_go,
    output logic [DATA_W-1:0] wr_data
);

    bus_st_e           state_q, state_d;
    logic              a8_q;
    logic [DATA_W-1:0] data_q;
    logic              take;
    logic              keep_data;
    logic              send;
    logic              slave_hit;

    assign slave_hit = (ev_byte[7:4] == PREAMBLE) && (ev_byte[3:2] == DEV_SEL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and decisions
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        keep_data = 1'b0;
        send      = 1'b0;
        wr_go     = 1'b0;
        if (ev_start) begin
            state_d = ST_SLAVE;
        end else if (ev_stop) begin
            wr_go   = (state_q == ST_HOLD);
            state_d = ST_IDLE;
        end else if (ev_byte_vld) begin
            unique case (state_q)
                ST_SLAVE: begin
                    if (slave_hit && !busy) begin
                        take    = 1'b1;
                        state_d = ev_byte[0] ? ST_READ : ST_ADDR;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_ADDR: begin
                    if ({a8_q, ev_byte} == REG_ADDR && !busy) begin
                        take    = 1'b1;
                        state_d = ST_DATA;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    if (!busy) begin
                        take      = 1'b1;
                        keep_data = 1'b1;
                        state_d   = ST_HOLD;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_HOLD:  state_d = ST_HOLD;
                ST_READ:  state_d = ST_SKIP;
                ST_IDLE:  state_d = ST_IDLE;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_IDLE;
            endcase
        end else if (ev_rd_req && state_q == ST_READ) begin
            send    = 1'b1;
            state_d = ST_IDLE;
        end
    end

    // captured address bit and data byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a8_q   <= 1'b0;
            data_q <= '0;
        end else begin
            if (ev_byte_vld && !ev_start && !ev_stop && state_q == ST_SLAVE) begin
                a8_q <= ev_byte[1];
            end
            if (keep_data) begin
                data_q <= ev_byte;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
            tx_vld  <= 1'b0;
            tx_byte <= '0;
        end else begin
            ack_vld <= ev_byte_vld;
            ack_ok  <= take;
            tx_vld  <= send;
            if (send) begin
                tx_byte <= cfg;
            end
        end
    end

    assign wr_data = data_q;

endmodule

// File: rtl/prot_ctlreg_store.sv
module prot_ctlreg_store
    import ctlreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_CFG = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg,
    output logic              fld_load
);

    localparam logic [DATA_W-1:0] RST_VAL = RST_CFG & FIELD_MASK;

    logic [DATA_W-1:0] cfg_q;
    logic              wel, rwel;

    assign wel      = cfg_q[B_WEL];
    assign rwel     = cfg_q[B_RWEL];
    assign fld_load = wr_go && wel && rwel && wr_data[B_RWEL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else if (fld_load) begin
            cfg_q <= wr_data & FIELD_MASK;
        end else if (wr_go) begin
            if (wr_data == CMD_SET_WEL) begin
                cfg_q[B_WEL]  <= 1'b1;
                cfg_q[B_RWEL] <= 1'b0;
            end else if (wr_data == CMD_SET_RWEL && wel) begin
                cfg_q[B_RWEL] <= 1'b1;
            end else if (wr_data == CMD_DISABLE) begin
                cfg_q[B_WEL]  <= 1'b0;
                cfg_q[B_RWEL] <= 1'b0;
            end
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/prot_ctlreg_busy.sv
module prot_ctlreg_busy #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int CW = (BUSY_CYC < 1) ? 1 : $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(BUSY_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_INIT;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/prot_ctlreg.sv
module prot_ctlreg
    import ctlreg_pkg::*;
#(
    parameter logic [1:0]        DEV_SEL  = 2'b00,
    parameter logic [8:0]        REG_ADDR = 9'h1FF,
    parameter int                BUSY_CYC = 8,
    parameter logic [DATA_W-1:0] RST_CFG  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte_vld,
    input  logic [DATA_W-1:0] ev_byte,
    input  logic              ev_rd_req,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              tx_vld,
    output logic [DATA_W-1:0] tx_byte,
    output logic [1:0]        wd_sel,
    output logic [1:0]        pup_sel,
    output logic [1:0]        bp_sel,
    output logic              busy_o
);

    logic              wr_go_w;
    logic [DATA_W-1:0] wr_data_w;
    logic [DATA_W-1:0] cfg_w;
    logic              fld_load_w;
    logic              busy_w;

    prot_ctlreg_seq #(
        .DEV_SEL  (DEV_SEL),
        .REG_ADDR (REG_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_start    (ev_start),
        .ev_stop     (ev_stop),
        .ev_byte_vld (ev_byte_vld),
        .ev_byte     (ev_byte),
        .ev_rd_req   (ev_rd_req),
        .busy        (busy_w),
        .cfg         (cfg_w),
        .ack_vld     (ack_vld),
        .ack_ok      (ack_ok),
        .tx_vld      (tx_vld),
        .tx_byte     (tx_byte),
        .wr_go       (wr_go_w),
        .wr_data     (wr_data_w)
    );

    prot_ctlreg_store #(
        .RST_CFG (RST_CFG)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go_w),
        .wr_data  (wr_data_w),
        .cfg      (cfg_w),
        .fld_load (fld_load_w)
    );

    prot_ctlreg_busy #(
        .BUSY_CYC (BUSY_CYC)
    ) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fld_load_w),
        .busy  (busy_w)
    );

    assign wd_sel  = {cfg_w[B_WD1],  cfg_w[B_WD0]};
    assign pup_sel = {cfg_w[B_PUP1], cfg_w[B_PUP0]};
    assign bp_sel  = {cfg_w[B_BP1],  cfg_w[B_BP0]};
    assign busy_o  = busy_w;

endmodule

// File: rtl/prot_ctlreg_chk.sv
module prot_ctlreg_chk
    import ctlreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_stop,
    input logic              ev_byte_vld,
    input logic              ev_rd_req,
    input logic              ack_vld,
    input logic              ack_ok,
    input logic              tx_vld,
    input logic [1:0]        wd_sel,
    input logic [1:0]        pup_sel,
    input logic [1:0]        bp_sel,
    input logic              busy_o,
    input logic [DATA_W-1:0] cfg,
    input logic              fld_load
);

    // R2
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte_vld |=> ack_vld);

    // R8
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_stop |=> $stable({wd_sel, pup_sel, bp_sel}));

    // R7
    commit_clears_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_load |=> (!cfg[B_WEL] && !cfg[B_RWEL]));

    // R7
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(ev_stop));

    // R10
    tx_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> $past(ev_rd_req));

    // R11
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte_vld && busy_o) |=> !ack_ok);

    // R6
    rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg[B_RWEL]) |-> $past(cfg[B_WEL]));

endmodule

bind prot_ctlreg prot_ctlreg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_stop     (ev_stop),
    .ev_byte_vld (ev_byte_vld),
    .ev_rd_req   (ev_rd_req),
    .ack_vld     (ack_vld),
    .ack_ok      (ack_ok),
    .tx_vld      (tx_vld),
    .wd_sel      (wd_sel),
    .pup_sel     (pup_sel),
    .bp_sel      (bp_sel),
    .busy_o      (busy_o),
    .cfg         (cfg_w),
    .fld_load    (fld_load_w)
);

// File: tb/prot_ctlreg_tb.sv
`timescale 1ns/1ps
module prot_ctlreg_tb;

    localparam int BUSY = 8;
    localparam logic [7:0] SLV_W  = 8'hB2;  // preamble, sel 00, a8=1, write
    localparam logic [7:0] SLV_R  = 8'hB3;
    localparam logic [7:0] ADR_LO = 8'hFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte_vld = 1'b0, ev_rd_req = 1'b0;
    logic [7:0] ev_byte = 8'h00;
    logic       ack_vld, ack_ok, tx_vld, busy_o;
    logic [7:0] tx_byte;
    logic [1:0] wd_sel, pup_sel, bp_sel;

    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] exp_cfg = 8'h00;

    always #2 clk = ~clk;

    prot_ctlreg #(.BUSY_CYC(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte_vld(ev_byte_vld), .ev_byte(ev_byte), .ev_rd_req(ev_rd_req),
        .ack_vld(ack_vld), .ack_ok(ack_ok), .tx_vld(tx_vld), .tx_byte(tx_byte),
        .wd_sel(wd_sel), .pup_sel(pup_sel), .bp_sel(bp_sel), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl(input logic [7:0] c, input logic [7:0] d);
        if (c[1] && c[2] && d[2]) return d & 8'hF9;
        if (d == 8'h02) return (c & 8'hF9) | 8'h02;
        if (d == 8'h06 && c[1]) return c | 8'h04;
        if (d == 8'h00) return c & 8'hF9;
        return c;
    endfunction

    task automatic pulse_start();
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic pulse_stop();
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        ev_byte = b; ev_byte_vld = 1'b1;
        @(negedge clk);
        ev_byte_vld = 1'b0;
        chk(ack_vld === 1'b1, "R2 ack_vld", int'(ack_vld), 1);
        ack = ack_ok;
    endtask

    task automatic rd_pulse(output bit got, output logic [7:0] v);
        ev_rd_req = 1'b1; @(negedge clk); ev_rd_req = 1'b0;
        got = tx_vld; v = tx_byte;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin n++; @(negedge clk); end
    endtask

    // read back and compare the whole register and the field ports (R10, R12)
    task automatic check_state(input string req);
        bit a, got; logic [7:0] v;
        pulse_start();
        send_byte(SLV_R, a);
        chk(a, "R10 read slave ack", int'(a), 1);
        rd_pulse(got, v);
        chk(got, "R10 tx_vld", int'(got), 1);
        chk(v == exp_cfg, req, v, exp_cfg);
        chk(wd_sel == {exp_cfg[6], exp_cfg[5]}, "R12 wd_sel", wd_sel, {exp_cfg[6], exp_cfg[5]});
        chk(pup_sel == {exp_cfg[7], exp_cfg[0]}, "R12 pup_sel", pup_sel, {exp_cfg[7], exp_cfg[0]});
        chk(bp_sel == {exp_cfg[4], exp_cfg[3]}, "R12 bp_sel", bp_sel, {exp_cfg[4], exp_cfg[3]});
        pulse_stop();
    endtask

    task automatic do_write(input logic [7:0] d);
        bit a, com; int n;
        com = exp_cfg[1] && exp_cfg[2] && d[2];
        pulse_start();
        send_byte(SLV_W, a);  chk(a, "R2 write slave ack", int'(a), 1);
        send_byte(ADR_LO, a); chk(a, "R3 address ack", int'(a), 1);
        send_byte(d, a);      chk(a, "R4 first data ack", int'(a), 1);
        pulse_stop();
        exp_cfg = mdl(exp_cfg, d);
        if (com) begin
            chk(busy_o === 1'b1, "R7 busy rises after stop", int'(busy_o), 1);
            wait_busy(n);
            chk(n == BUSY, "R7 busy length", n, BUSY);
        end else begin
            chk(busy_o === 1'b0, "R8 no busy without commit", int'(busy_o), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit a, got; logic [7:0] v; int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!ack_vld && !ack_ok && !tx_vld && !busy_o, "R1 control outputs",
            {ack_vld, ack_ok, tx_vld, busy_o}, 0);
        chk({wd_sel, pup_sel, bp_sel} == 6'd0, "R1 fields", {wd_sel, pup_sel, bp_sel}, 0);
        check_state("R1 register after reset");

        // R5 R6 R7 R8: full data sweep after the unlock sequence
        for (int d = 0; d < 256; d++) begin
            do_write(8'h02);
            do_write(8'h06);
            do_write(8'(d));
            check_state("R7 unlocked write");
            do_write(8'h00);
        end

        // R8 R6: data sweep with latches clear
        for (int d = 0; d < 256; d++) begin
            do_write(8'(d));
            check_state("R8 locked write");
            do_write(8'h00);
        end
        do_write(8'h06);
        check_state("R6 rwel without wel");

        // R2 slave byte sweep
        for (int s = 0; s < 256; s++) begin
            bit e;
            e = (s[7:2] == 6'b101100);
            pulse_start();
            send_byte(8'(s), a);
            chk(a == e, "R2 slave byte decode", int'(a), int'(e));
            if (!e) begin
                send_byte(8'hFF, a);
                chk(!a, "R2 bytes after refused slave", int'(a), 0);
            end
            pulse_stop();
        end

        // R3 address sweep, with latches open so any leak would show
        do_write(8'h02);
        do_write(8'h06);
        for (int ad = 0; ad < 512; ad++) begin
            bit e;
            e = (ad == 511);
            pulse_start();
            send_byte({4'b1011, 2'b00, ad[8], 1'b0}, a);
            send_byte(ad[7:0], a);
            chk(a == e, "R3 address decode", int'(a), int'(e));
            if (!e) begin
                send_byte(8'hFC, a);
                chk(!a, "R3 data after bad address", int'(a), 0);
            end
            pulse_stop();   // R9 stop before data
        end
        check_state("R3 R9 no change after address sweep");

        // R9 start between data and stop
        pulse_start();
        send_byte(SLV_W, a); send_byte(ADR_LO, a); send_byte(8'hFC, a);
        pulse_start();
        pulse_stop();
        chk(busy_o === 1'b0, "R9 no busy after aborted write", int'(busy_o), 0);
        check_state("R9 repeated start aborts");

        // R4 only the first data byte
        pulse_start();
        send_byte(SLV_W, a); send_byte(ADR_LO, a);
        send_byte(8'hA4, a); chk(a, "R4 first data", int'(a), 1);
        send_byte(8'h5C, a); chk(!a, "R4 second data refused", int'(a), 0);
        send_byte(8'h3B, a); chk(!a, "R4 third data refused", int'(a), 0);
        pulse_stop();
        exp_cfg = 8'hA0;
        wait_busy(n);
        check_state("R4 first byte committed");

        // R10 one byte per read, no stop needed
        pulse_start();
        send_byte(SLV_R, a);
        rd_pulse(got, v);
        chk(got && v == exp_cfg, "R10 first read byte", v, exp_cfg);
        rd_pulse(got, v);
        chk(!got, "R10 second request no tx", int'(got), 0);
        check_state("R10 read without stop");

        // R11 slave byte in last busy cycle, then first free cycle
        for (int w = BUSY - 2; w <= BUSY - 1; w++) begin
            bit e;
            e = (w == BUSY - 1);
            do_write(8'h02);
            do_write(8'h06);
            pulse_start();
            send_byte(SLV_W, a); send_byte(ADR_LO, a); send_byte(8'hFC, a);
            pulse_stop();
            exp_cfg = 8'hF8;
            pulse_start();
            repeat (w) @(negedge clk);
            send_byte(SLV_W, a);
            chk(a == e, "R11 slave byte at busy boundary", int'(a), int'(e));
            pulse_stop();
            wait_busy(n);
        end
        check_state("R11 state after busy tests");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule